// File: doc/BRIEF.md
# DVMA Translator Register Bank

This block holds the software-visible state of an I/O address translator used for direct memory access. A host reaches it through a single-cycle 32-bit bus that carries a byte offset. The two low offset bits are dropped to form a word index. Each register applies its own write mask and its own bits forced to one.

The bank turns the range code in the control register into a window start address for the translator. It also passes the enable bit and the page-table base to the translator. When the translator finds a bad mapping, it pulses a fault strobe with a status word and a page address. The bank captures both and raises a level interrupt. Any host read or write of either fault register drops that interrupt.

Top module: `iommu_csr_bank`

## Requirements
- R1: Only 32-bit accesses exist. The word index is `bus_addr >> 2`, so bits 1:0 of the offset have no effect on which register is reached.
- R2: Control (offset 0x0000) keeps only the bits in 0x0000001D. Bits 31:24 always read as the `IMPL_VER` parameter, and bit 0 drives `xlat_en`.
- R3: `win_start` equals 0xFFFFFFFF minus (16 MB << code) plus 1, where code is control bits 4:2. Code 0 gives 0xFF000000, code 3 gives 0xF8000000 and code 7 gives 0x80000000.
- R4: Page-table base (offset 0x0004) keeps only the bits in 0x07FFFC00, and its value drives `pt_base`.
- R5: Arbiter enable (offset 0x1008) keeps the bits in 0x801F000F, and bit 0 always reads as one.
- R6: Fault status (offset 0x1000) keeps the bits in 0xFF0FFFFF with bit 23 forced to one. Fault address (offset 0x1004) stores all 32 bits.
- R7: A `fault_strobe` cycle loads fault status with `fault_status | 0x00800000` and fault address with `fault_addr`, and sets `irq` on the next edge. In the same cycle, the capture wins over a bus write to either register.
- R8: A host read or write of fault status or fault address clears `irq`, unless a strobe arrives in that cycle. Accesses to other registers leave `irq` unchanged.
- R9: Arbitration enable (offset 0x2000) keeps bits 20:16 and always reads bit 3 as one. The slot configuration registers (offsets 0x1010 + 4*k) keep only the bits in 0x00010003.
- R10: A write to mask ID (offset 0x3018) ORs data bits 23:0 into the current value. Its bits are never cleared by a write.
- R11: After reset, control reads `IMPL_VER` << 24, arbitration enable reads 0x8, fault status reads 0x00800000, arbiter enable reads 0x3, mask ID reads 0x23000000, `irq` is 0, and every other register reads 0.
- R12: Unlisted word indices below `SCRATCH_WORDS` (a power of two) are plain 32-bit storage. This includes the flush words at 0x0014 and 0x0018. Unlisted indices at or above it read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| fault_strobe | input | 1 | Translator fault capture pulse |
| fault_status | input | 32 | Status word to capture |
| fault_addr | input | 32 | Faulting page address to capture |
| irq | output | 1 | Level fault interrupt |
| xlat_en | output | 1 | Translation enable |
| win_start | output | 32 | Start of the translation window |
| pt_base | output | 32 | Page-table base value |

## Verification
Two events can fall in the same cycle: a fault capture from the translator and a host write to a fault register. Both touch the same storage and the interrupt. The bench raises `fault_strobe` in the cycle that carries a bus write to fault status, and in another cycle that carries a write to fault address. It then reads both registers back and expects the captured values and a set interrupt. A following plain read must drop the interrupt, which confirms that the clear path and the capture path are ordered correctly.

// File: rtl/iommu_csr_bank.sv
module iommu_csr_bank #(
  parameter int          ADDR_W        = 14,
  parameter int          SCRATCH_WORDS = 16,
  parameter int          NUM_SLOTS     = 4,
  parameter logic [7:0]  IMPL_VER      = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              fault_strobe,
  input  logic [31:0]       fault_status,
  input  logic [31:0]       fault_addr,
  output logic              irq,
  output logic              xlat_en,
  output logic [31:0]       win_start,
  output logic [31:0]       pt_base
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SW    = $clog2(SCRATCH_WORDS);

  localparam logic [IDX_W-1:0] IX_CTRL  = IDX_W'(32'h000);
  localparam logic [IDX_W-1:0] IX_BASE  = IDX_W'(32'h001);
  localparam logic [IDX_W-1:0] IX_FSTAT = IDX_W'(32'h400);
  localparam logic [IDX_W-1:0] IX_FADDR = IDX_W'(32'h401);
  localparam logic [IDX_W-1:0] IX_AEN   = IDX_W'(32'h402);
  localparam logic [IDX_W-1:0] IX_SLOT0 = IDX_W'(32'h404);
  localparam logic [IDX_W-1:0] IX_ARB   = IDX_W'(32'h800);
  localparam logic [IDX_W-1:0] IX_MID   = IDX_W'(32'hC06);

  localparam logic [31:0] M_CTRL  = 32'h0000_001D;
  localparam logic [31:0] M_BASE  = 32'h07FF_FC00;
  localparam logic [31:0] M_AEN   = 32'h801F_000F;
  localparam logic [31:0] M_FSTAT = 32'hFF0F_FFFF;
  localparam logic [31:0] F_FSTAT = 32'h0080_0000;
  localparam logic [31:0] M_ARB   = 32'h001F_0000;
  localparam logic [31:0] F_ARB   = 32'h0000_0008;
  localparam logic [31:0] M_SLOT  = 32'h0001_0003;
  localparam logic [31:0] M_MID   = 32'h00FF_FFFF;
  localparam logic [31:0] VER     = {IMPL_VER, 24'h0};

  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic             fault_acc;
  logic [31:0]      ctrl_q, base_q, fstat_q, faddr_q, aen_q, arb_q, mid_q;
  logic [31:0]      slot_q [NUM_SLOTS];
  logic [31:0]      scr_q  [SCRATCH_WORDS];
  logic             irq_q;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign wr_en     = bus_sel && bus_wr;
  assign fault_acc = bus_sel && (idx == IX_FSTAT || idx == IX_FADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= VER;
      base_q  <= '0;
      fstat_q <= F_FSTAT;
      faddr_q <= '0;
      aen_q   <= 32'h0000_0003;
      arb_q   <= F_ARB;
      mid_q   <= 32'h2300_0000;
      irq_q   <= 1'b0;
      for (int k = 0; k < NUM_SLOTS; k++) slot_q[k] <= '0;
      for (int k = 0; k < SCRATCH_WORDS; k++) scr_q[k] <= '0;
    end else begin
      if (wr_en) begin
        unique case (idx)
          IX_CTRL:  ctrl_q  <= (bus_wdata & M_CTRL) | VER;
          IX_BASE:  base_q  <= bus_wdata & M_BASE;
          IX_FSTAT: fstat_q <= (bus_wdata & M_FSTAT) | F_FSTAT;
          IX_FADDR: faddr_q <= bus_wdata;
          IX_AEN:   aen_q   <= (bus_wdata & M_AEN) | 32'h1;
          IX_ARB:   arb_q   <= (bus_wdata & M_ARB) | F_ARB;
          IX_MID:   mid_q   <= mid_q | (bus_wdata & M_MID);
          default: begin
            if (idx < IDX_W'(SCRATCH_WORDS))
              scr_q[idx[SW-1:0]] <= bus_wdata;
          end
        endcase
        for (int k = 0; k < NUM_SLOTS; k++)
          if (idx == IX_SLOT0 + IDX_W'(k)) slot_q[k] <= bus_wdata & M_SLOT;
      end
      if (fault_strobe) begin
        fstat_q <= fault_status | F_FSTAT;
        faddr_q <= fault_addr;
        irq_q   <= 1'b1;
      end else if (fault_acc) begin
        irq_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      IX_CTRL:  bus_rdata = ctrl_q;
      IX_BASE:  bus_rdata = base_q;
      IX_FSTAT: bus_rdata = fstat_q;
      IX_FADDR: bus_rdata = faddr_q;
      IX_AEN:   bus_rdata = aen_q;
      IX_ARB:   bus_rdata = arb_q;
      IX_MID:   bus_rdata = mid_q;
      default: begin
        if (idx < IDX_W'(SCRATCH_WORDS)) bus_rdata = scr_q[idx[SW-1:0]];
      end
    endcase
    for (int k = 0; k < NUM_SLOTS; k++)
      if (idx == IX_SLOT0 + IDX_W'(k)) bus_rdata = slot_q[k];
  end

  assign irq       = irq_q;
  assign xlat_en   = ctrl_q[0];
  assign pt_base   = base_q;
  assign win_start = ~((32'h0100_0000 << ctrl_q[4:2]) - 32'd1);
endmodule

// File: rtl/iommu_csr_chk.sv
module iommu_csr_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              fault_strobe,
  input logic [31:0]       fault_addr,
  input logic              irq,
  input logic [31:0]       faddr_q,
  input logic [31:0]       mid_q
);
  logic [ADDR_W-3:0] ix;
  logic              facc;
  assign ix   = bus_addr[ADDR_W-1:2];
  assign facc = bus_sel && (ix == (ADDR_W-2)'(32'h400) || ix == (ADDR_W-2)'(32'h401));

  AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_strobe |=> irq); // R7
  AST_FAULT_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_strobe |=> faddr_q == $past(fault_addr)); // R7
  AST_ACCESS_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (facc && !fault_strobe) |=> !irq); // R8
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !facc) |=> irq); // R8
  AST_MASKID_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_q & $past(mid_q)) == $past(mid_q)); // R10
  AST_AEN_LSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ix == (ADDR_W-2)'(32'h402)) |-> bus_rdata[0]); // R5
endmodule

bind iommu_csr_bank iommu_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .fault_strobe(fault_strobe),
  .fault_addr(fault_addr), .irq(irq), .faddr_q(faddr_q), .mid_q(mid_q)
);

// File: tb/tb_iommu_csr_bank.sv
module tb_iommu_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        fault_strobe = 1'b0;
  logic [31:0] fault_status = '0, fault_addr = '0;
  logic        irq, xlat_en;
  logic [31:0] win_start, pt_base;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iommu_csr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fault_strobe(fault_strobe), .fault_status(fault_status),
    .fault_addr(fault_addr), .irq(irq), .xlat_en(xlat_en),
    .win_start(win_start), .pt_base(pt_base)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rdchk(string tag, logic [13:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R11 irq", {31'b0, irq}, 0);
    rdchk("R11 ctrl", 14'h0000, 32'h4100_0000);
    rdchk("R11 arben", 14'h2000, 32'h8);
    rdchk("R11 fstat", 14'h1000, 32'h0080_0000);
    rdchk("R11 aen", 14'h1008, 32'h3);
    rdchk("R11 maskid", 14'h3018, 32'h2300_0000);
    rdchk("R11 base", 14'h0004, 0);
    chk("R3 reset window", win_start, 32'hFF00_0000);
  endtask

  task automatic t_ctrl;
    wr(14'h0000, 32'hFFFF_FFFF);
    rdchk("R2 ctrl mask", 14'h0000, 32'h4100_001D);
    chk("R2 enable", {31'b0, xlat_en}, 1);
    chk("R3 code7", win_start, 32'h8000_0000);
    wr(14'h0000, 32'h0000_000C);
    chk("R3 code3", win_start, 32'hF800_0000);
    chk("R2 disable", {31'b0, xlat_en}, 0);
    wr(14'h0000, 32'h0000_0001);
    chk("R3 code0", win_start, 32'hFF00_0000);
  endtask

  task automatic t_base_aen;
    wr(14'h0004, 32'hFFFF_FFFF);
    chk("R4 base", pt_base, 32'h07FF_FC00);
    wr(14'h1008, 32'hFFFF_FFFE);
    rdchk("R5 aen", 14'h1008, 32'h801F_000F);
    wr(14'h1008, 32'h0);
    rdchk("R5 aen bit0", 14'h1008, 32'h1);
  endtask

  task automatic t_fault_regs;
    wr(14'h1000, 32'hFFFF_FFFF);
    rdchk("R6 fstat mask", 14'h1000, 32'hFF8F_FFFF);
    wr(14'h1000, 32'h0);
    rdchk("R6 fstat force", 14'h1000, 32'h0080_0000);
    wr(14'h1004, 32'hA5A5_5A5A);
    rdchk("R6 faddr", 14'h1004, 32'hA5A5_5A5A);
  endtask

  task automatic pulse(logic [31:0] s, logic [31:0] a);
    @(negedge clk);
    fault_strobe = 1; fault_status = s; fault_addr = a;
    @(negedge clk);
    fault_strobe = 0;
  endtask

  task automatic t_capture_clear;
    logic [31:0] d;
    pulse(32'hC002_0000, 32'h1234_5000);
    chk("R7 irq set", {31'b0, irq}, 1);
    wr(14'h0000, 32'h1);
    chk("R8 other access keeps irq", {31'b0, irq}, 1);
    rdchk("R7 fstat", 14'h1000, 32'hC082_0000);
    chk("R8 read clears irq", {31'b0, irq}, 0);
    rdchk("R7 faddr", 14'h1004, 32'h1234_5000);
    pulse(32'h0, 32'h0);
    wr(14'h1004, 32'h0);
    chk("R8 write clears irq", {31'b0, irq}, 0);
    pulse(32'h0, 32'h0);
    rd(14'h1007, d);
    chk("R1 low bits ignored read", d, 32'h0);
    chk("R8 faddr read clears irq", {31'b0, irq}, 0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    fault_strobe = 1; fault_status = 32'h4000_0000; fault_addr = 32'hFEED_0000;
    bus_sel = 1; bus_wr = 1; bus_addr = 14'h1000; bus_wdata = 32'h0;
    @(negedge clk);
    fault_strobe = 0; bus_sel = 0; bus_wr = 0;
    chk("R7 collision irq", {31'b0, irq}, 1);
    @(negedge clk);
    fault_strobe = 1; fault_status = 32'h1000_0000; fault_addr = 32'hBEEF_0000;
    bus_sel = 1; bus_wr = 1; bus_addr = 14'h1004; bus_wdata = 32'h1;
    @(negedge clk);
    fault_strobe = 0; bus_sel = 0; bus_wr = 0;
    chk("R7 collision irq 2", {31'b0, irq}, 1);
    rdchk("R7 collision fstat", 14'h1000, 32'h1080_0000);
    rdchk("R7 collision faddr", 14'h1004, 32'hBEEF_0000);
    chk("R8 cleared after", {31'b0, irq}, 0);
  endtask

  task automatic t_arb_slots;
    wr(14'h2000, 32'hFFFF_FFF7);
    rdchk("R9 arben", 14'h2000, 32'h001F_0008);
    for (int k = 0; k < 4; k++) wr(14'h1010 + 14'(4*k), 32'hFFFF_FFF0 | 32'(k));
    for (int k = 0; k < 4; k++)
      rdchk("R9 slot", 14'h1010 + 14'(4*k), 32'h0001_0000 | (32'(k) & 32'h3));
  endtask

  task automatic t_maskid;
    wr(14'h3018, 32'hFF00_00F0);
    rdchk("R10 or", 14'h3018, 32'h2300_00F0);
    wr(14'h3018, 32'h0000_000F);
    rdchk("R10 accumulate", 14'h3018, 32'h2300_00FF);
    wr(14'h3018, 32'h0);
    rdchk("R10 no clear", 14'h3018, 32'h2300_00FF);
  endtask

  task automatic t_scratch;
    wr(14'h0008, 32'hDEAD_BEEF);
    rdchk("R12 scratch", 14'h0008, 32'hDEAD_BEEF);
    wr(14'h0014, 32'hFFFF_FFFF);
    rdchk("R12 flush word", 14'h0014, 32'hFFFF_FFFF);
    wr(14'h001B, 32'h1357_9BDF);
    rdchk("R1 low bits ignored write", 14'h0018, 32'h1357_9BDF);
    wr(14'h0040, 32'hFFFF_FFFF);
    rdchk("R12 out of range", 14'h0040, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_base_aen();
    t_fault_regs();
    t_capture_clear();
    t_collision();
    t_arb_slots();
    t_maskid();
    t_scratch();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule